// File: doc/BRIEF.md
# Three-Source Fused Shift-Logic Unit

This block is a pipelined 32-bit integer unit with three source operands. An issue carries an opcode, a shift amount or logic operand (`src_a`), a data operand (`src_b`) and a mask or merge operand (`src_c`). The unit performs one first-stage operation, which is a left shift, a right shift or a bitwise AND. It then applies a second operation with the third operand, which is either an AND mask or an OR merge.

Because the shift and the masking or merging step are fused, a field extract takes one issue: shift the field down and mask it. A field insert also takes one issue: shift the field up and OR it into the existing word. The result is registered and returned with a valid pulse one clock after the issue. Opcodes that the unit does not define return zero and raise an illegal-operation flag.

Top module: `fsl_unit`

## Requirements
- R1: While `rst_n` is low, and until the first issue after reset, `res_valid`, `res_illegal` and `res_data` are all zero.
- R2: Opcode 3'd0 returns `(src_b >> amt) & src_c`. The right shift is logical and fills with zeros.
- R3: Opcode 3'd1 returns `(src_b << amt) & src_c`.
- R4: Opcode 3'd2 returns `(src_b >> amt) | src_c`. The right shift is logical.
- R5: Opcode 3'd3 returns `(src_b << amt) | src_c`.
- R6: Opcode 3'd4 returns `(src_b & src_a) | src_c`.
- R7: The shift amount `amt` is `src_a[4:0]`. The upper bits of `src_a` are ignored by shifts, so amounts of 32 and above wrap modulo 32.
- R8: An issue sampled on a rising edge with `issue_valid` high produces `res_valid` high for the following cycle only. Back-to-back issues each produce their own result in issue order.
- R9: Opcodes 3'd5, 3'd6 and 3'd7 return `res_data` of zero with `res_illegal` high in the result cycle. `res_illegal` is never high when `res_valid` is low.
- R10: In a cycle that follows no issue, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | The operands and opcode on this cycle form an issue |
| issue_op | input | 3 | Opcode |
| src_a | input | 32 | Shift amount (low 5 bits) or AND operand |
| src_b | input | 32 | Data operand |
| src_c | input | 32 | Mask or merge operand |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 32 | Result word |
| res_illegal | output | 1 | The result came from an undefined opcode |

## Verification
The assertions take for granted that `issue_valid` and `issue_op` are known at every rising edge after reset. They also assume that the three operands are known whenever `issue_valid` is high, because the mask and merge properties compare the result against the previous cycle's `src_c`. The stimulus meets these assumptions: the driver changes inputs only on falling edges, always drives fully defined values, and leaves the operands at defined idle values between issues. Random and corner-case issues cover all eight opcodes, shift amounts at and beyond the word width, and both gapped and back-to-back issue patterns.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

   typedef enum logic [2:0] {
      OP_SHR_MASK  = 3'd0,
      OP_SHL_MASK  = 3'd1,
      OP_SHR_MERGE = 3'd2,
      OP_SHL_MERGE = 3'd3,
      OP_AND_MERGE = 3'd4
   } fsl_op_e;

   typedef struct packed {
      logic use_shift;   // first stage is a shift, else bitwise AND
      logic shift_left;  // shift direction
      logic merge;       // second stage ORs src_c, else ANDs it
      logic illegal;     // opcode is undefined
   } fsl_ctl_t;

   localparam int unsigned OP_W = 3;

endpackage

// File: rtl/fsl_decode.sv
module fsl_decode
   import fsl_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output fsl_ctl_t        ctl
);

   always_comb begin
      ctl = '{use_shift: 1'b0, shift_left: 1'b0, merge: 1'b0, illegal: 1'b0};
      case (op)
         OP_SHR_MASK:  begin ctl.use_shift = 1'b1; end
         OP_SHL_MASK:  begin ctl.use_shift = 1'b1; ctl.shift_left = 1'b1; end
         OP_SHR_MERGE: begin ctl.use_shift = 1'b1; ctl.merge = 1'b1; end
         OP_SHL_MERGE: begin ctl.use_shift = 1'b1; ctl.shift_left = 1'b1; ctl.merge = 1'b1; end
         OP_AND_MERGE: begin ctl.merge = 1'b1; end
         default:      begin ctl.illegal = 1'b1; end
      endcase
   end

endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          STAGED  = 1'b1,
   localparam int unsigned SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [SH_W-1:0]   amount,
   input  logic              left,
   output logic [DATA_W-1:0] data_out
);

   function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
      return r;
   endfunction

   generate
      if (STAGED) begin : g_staged
         // logarithmic right shifter; left shifts reuse it by bit reversal
         logic [DATA_W-1:0] stage [0:SH_W];
         assign stage[0] = left ? bit_rev(data_in) : data_in;
         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            assign stage[s+1] = amount[s] ? (stage[s] >> (1 << s)) : stage[s];
         end
         assign data_out = left ? bit_rev(stage[SH_W]) : stage[SH_W];
      end else begin : g_direct
         assign data_out = left ? (data_in << amount) : (data_in >> amount);
      end
   endgenerate

endmodule

// File: rtl/fsl_combine.sv
module fsl_combine
   import fsl_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fsl_ctl_t          ctl,
   input  logic [DATA_W-1:0] shifted,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] opnd_c,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] first;
   logic [DATA_W-1:0] second;

   always_comb begin
      first  = ctl.use_shift ? shifted : (opnd_b & opnd_a);
      second = ctl.merge ? (first | opnd_c) : (first & opnd_c);
      result = ctl.illegal ? '0 : second;
   end

endmodule

// File: rtl/fsl_unit.sv
module fsl_unit
   import fsl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter bit          STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [2:0]        issue_op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] src_c,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              res_illegal
);

   localparam int unsigned SH_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("fsl_unit: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   fsl_ctl_t          ctl;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] comb_res;

   fsl_decode u_dec (
      .op  (issue_op),
      .ctl (ctl)
   );

   fsl_shifter #(.DATA_W(DATA_W), .STAGED(STAGED)) u_shf (
      .data_in  (src_b),
      .amount   (src_a[SH_W-1:0]),
      .left     (ctl.shift_left),
      .data_out (shifted)
   );

   fsl_combine #(.DATA_W(DATA_W)) u_cmb (
      .ctl     (ctl),
      .shifted (shifted),
      .opnd_a  (src_a),
      .opnd_b  (src_b),
      .opnd_c  (src_c),
      .result  (comb_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_illegal <= 1'b0;
      end else begin
         res_valid   <= issue_valid;
         res_illegal <= issue_valid & ctl.illegal;
         if (issue_valid) res_data <= comb_res;
      end
   end

endmodule

// File: rtl/fsl_unit_chk.sv
module fsl_unit_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [2:0]        issue_op,
   input logic [DATA_W-1:0] src_c,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              res_illegal
);

   p_issue_to_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> res_valid);

   p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> !res_valid);

   p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op >= 3'd5) |=> (res_illegal && res_data == '0));

   p_illegal_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> res_valid);

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(res_data));

   p_mask_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 3'd0) |=> ((res_data & ~$past(src_c)) == '0));

   p_mask_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 3'd1) |=> ((res_data & ~$past(src_c)) == '0));

   p_merge_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 3'd2) |=> ((res_data & $past(src_c)) == $past(src_c)));

   p_merge_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 3'd3) |=> ((res_data & $past(src_c)) == $past(src_c)));

   p_merge_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 3'd4) |=> ((res_data & $past(src_c)) == $past(src_c)));

endmodule

bind fsl_unit fsl_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_op    (issue_op),
   .src_c       (src_c),
   .res_valid   (res_valid),
   .res_data    (res_data),
   .res_illegal (res_illegal)
);

// File: tb/fsl_unit_test.sv
module fsl_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [2:0]  issue_op = 3'd0;
   logic [31:0] src_a = '0, src_b = '0, src_c = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        res_illegal;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   logic [32:0] exp_q [$];
   string       req_q [$];
   logic [31:0] last_res = '0;

   always #10 clk = ~clk;

   fsl_unit uut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
      .src_a(src_a), .src_b(src_b), .src_c(src_c),
      .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
   );

   // reference: {illegal, result}
   function automatic logic [32:0] ref_model(input logic [2:0] op, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] c);
      logic [4:0] amt = a[4:0];
      case (op)
         3'd0: return {1'b0, (b >> amt) & c};
         3'd1: return {1'b0, (b << amt) & c};
         3'd2: return {1'b0, (b >> amt) | c};
         3'd3: return {1'b0, (b << amt) | c};
         3'd4: return {1'b0, (b & a) | c};
         default: return {1'b1, 32'h0};
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op, input logic [31:0] a);
      if (op >= 3'd5) return "R9";
      if (op != 3'd4 && a[31:5] != 0) return "R7";
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one issue per call, drives on the falling edge
   task automatic issue(input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c);
      @(negedge clk);
      issue_valid = 1'b1; issue_op = op; src_a = a; src_b = b; src_c = c;
      exp_q.push_back(ref_model(op, a, b, c));
      req_q.push_back(req_of(op, a));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         issue_valid = 1'b0;
      end
   endtask

   // monitor: compares on falling edges, away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected valid", 33'd1, 33'd0);
            end else begin
               logic [32:0] e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check(r, {res_illegal, res_data}, e);
               last_res = e[31:0];
            end
         end else begin
            // R10: no new result, data holds and no illegal flag (R9)
            check("R10 hold", {res_illegal, res_data}, {1'b0, last_res});
         end
      end
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 valid", {32'h0, res_valid}, 33'd0);
      check("R1 data", {1'b0, res_data}, 33'd0);
      check("R1 illegal", {32'h0, res_illegal}, 33'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {res_illegal, res_data}, 33'd0);
      mon_on = 1'b1;

      // directed corners, gapped issues (R8 single pulse)
      issue(3'd0, 32'd4, 32'hF000_00F0, 32'h0000_000F);   // R2 field extract
      idle(2);
      issue(3'd0, 32'd31, 32'h8000_0000, 32'hFFFF_FFFF);  // R2 logical fill
      issue(3'd1, 32'd8, 32'h0000_00AB, 32'h0000_FF00);   // R3
      issue(3'd2, 32'd0, 32'h1234_5678, 32'h0000_0000);   // R4 amount zero
      issue(3'd3, 32'd16, 32'h0000_BEEF, 32'h0000_1234);  // R5 field insert
      issue(3'd4, 32'h0F0F_0F0F, 32'hFF00_FF00, 32'h8000_0001); // R6
      issue(3'd0, 32'd32, 32'hDEAD_BEEF, 32'hFFFF_FFFF);  // R7 wrap to 0
      issue(3'd1, 32'd33, 32'h0000_0001, 32'hFFFF_FFFF);  // R7 wrap to 1
      issue(3'd2, 32'hFFFF_FFE3, 32'h8000_0000, 32'h0);   // R7 amount 3
      issue(3'd5, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R9
      idle(1);
      issue(3'd7, 32'd0, 32'h1, 32'h1);                   // R9
      issue(3'd6, 32'd2, 32'h3, 32'h3);                   // R9 back-to-back
      idle(3);                                            // R10 hold after illegal

      // random issues with random gaps
      for (int k = 0; k < 400; k++) begin
         issue($urandom_range(7, 0), $urandom, $urandom, $urandom);
         if ($urandom_range(3, 0) == 0) idle($urandom_range(3, 1));
      end
      idle(4);
      // R8: every issue produced exactly one result
      check("R8 drained", {1'b0, 32'(exp_q.size())}, 33'd0);
      done = 1'b1;
      summary();
   end

endmodule